// File: doc/BRIEF.md
# Raw Video Frame Start Qualifier

This block sits on one input port of a receiver for raw parallel video carried over a serial link. It takes the frame-valid and line-valid framing strobes, which behave like vertical and horizontal sync, along with the pixel word. Each strobe goes through its own configurable polarity inversion. The block then checks the first line of every frame against a programmable setup time. The setup time is the number of link clocks during which frame-valid has been active before line-valid first goes active.

When the setup is long enough, the first line is forwarded unchanged. When it is too short, the default is to drop the whole first line. A configuration bit selects the other option: the line is forwarded, with the pixel-valid strobe held low until the setup count reaches the threshold, so the line arrives missing its leading pixels. Every dropped or shortened first line sets a sticky error flag, which a clear pulse resets. No timing check is applied when a frame ends.

The polarity, threshold and forward/drop settings are captured into shadow registers only while the qualified frame-valid is inactive. A change made during a frame therefore takes effect in the next frame. The threshold shadow resets to 128.

Top module: `raw_frame_qualifier`

## Requirements
- R1: After reset, `fv_out`, `lv_out`, `pix_vld` and `err_flag` are all 0.
- R2: `cfg_fv_inv` = 1 makes a low `fv_in` the active level, and `cfg_lv_inv` = 1 does the same for `lv_in`. The two settings are independent, and `fv_out`/`lv_out` are always active high.
- R3: Setup time is the number of clocks with qualified FV active strictly before the first clock of the first line with LV active. If this count is greater than or equal to the threshold, the whole first line appears on `lv_out` and `pix_vld`.
- R4: If the setup is below the threshold and `cfg_fwd_trunc` = 0, no cycle of the first line reaches `lv_out` or `pix_vld`, and `err_flag` is set.
- R5: If the setup is below the threshold and `cfg_fwd_trunc` = 1, the first line is shown in full on `lv_out`. `pix_vld` is asserted only on the line cycles at which the running FV-active count has reached the threshold, and `err_flag` is set.
- R6: Every line after the first line of a frame is forwarded in full, whatever the outcome of the setup check.
- R7: `err_flag` stays set until a one-cycle `err_clr` pulse. If a new error and `err_clr` fall in the same cycle, the error wins.
- R8: Changes to the configuration inputs while FV is active do not affect the current frame. They apply from the next frame.
- R9: LV that is active while FV is inactive is suppressed. A line already active when FV rises is not treated as the first line, and it is suppressed until LV goes inactive.
- R10: With a threshold of 0, a first line whose LV rises in the same clock as FV is forwarded in full. With a threshold of 1, the same line counts as short.
- R11: FV may fall while LV is still active. `lv_out` ends with FV, and no error is raised.
- R12: `fv_out`, `lv_out`, `pix_vld` and `pix_out` follow the inputs with a latency of two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fv_in | input | 1 | Raw frame-valid strobe |
| lv_in | input | 1 | Raw line-valid strobe |
| pix_in | input | DATA_W | Raw pixel word |
| cfg_fv_inv | input | 1 | 1: frame-valid is active low |
| cfg_lv_inv | input | 1 | 1: line-valid is active low |
| cfg_min_time | input | THR_W | Minimum FV-to-LV setup, in link clocks |
| cfg_fwd_trunc | input | 1 | 1: forward a short first line truncated; 0: drop it |
| err_clr | input | 1 | Pulse that clears the sticky error flag |
| fv_out | output | 1 | Qualified frame-valid, active high |
| lv_out | output | 1 | Qualified line-valid, active high |
| pix_vld | output | 1 | Pixel word valid |
| pix_out | output | DATA_W | Pixel word, delayed to match the strobes |
| err_flag | output | 1 | Sticky flag for a first line with short setup |

## Verification
Two events can land in the same cycle: the error raised by a short first line and a software clear. The bench times `err_clr` so that it is sampled on the exact clock at which the delayed LV edge is judged. It then expects the flag to read 1, and a later lone clear to bring it back to 0. A second collision happens when FV and LV rise in the same clock. Here the bench runs thresholds 0 and 1 and expects a full first line in the first case and a dropped one in the second.

// File: rtl/rfq_pkg.sv
`timescale 1ns/1ps
package rfq_pkg;
    typedef enum logic [2:0] {
        LS_IDLE  = 3'd0,
        LS_ARMED = 3'd1,
        LS_PASS  = 3'd2,
        LS_DROP  = 3'd3,
        LS_TRUNC = 3'd4
    } line_st_e;
endpackage

// File: rtl/rfq_input_stage.sv
`timescale 1ns/1ps
// Polarity conditioning plus shadow capture of configuration between frames.
module rfq_input_stage #(
    parameter int DATA_W  = 12,
    parameter int THR_W   = 16,
    parameter int MIN_RST = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fv_raw,
    input  logic              lv_raw,
    input  logic [DATA_W-1:0] data_raw,
    input  logic              cfg_fv_inv,
    input  logic              cfg_lv_inv,
    input  logic [THR_W-1:0]  cfg_min,
    input  logic              cfg_fwd,
    output logic              fv_q,
    output logic              lv_q,
    output logic [DATA_W-1:0] data_q,
    output logic [THR_W-1:0]  thr_q,
    output logic              fwd_q
);
    localparam logic [THR_W-1:0] THR_RST = THR_W'(MIN_RST);

    typedef struct packed {
        logic              fv;
        logic              lv;
        logic [DATA_W-1:0] data;
        logic              fv_inv;
        logic              lv_inv;
        logic [THR_W-1:0]  thr;
        logic              fwd;
    } in_st_t;

    in_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.fv) begin
            st_d.fv_inv = cfg_fv_inv;
            st_d.lv_inv = cfg_lv_inv;
            st_d.thr    = cfg_min;
            st_d.fwd    = cfg_fwd;
        end
        st_d.fv   = fv_raw ^ st_q.fv_inv;
        st_d.lv   = lv_raw ^ st_q.lv_inv;
        st_d.data = data_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.thr <= THR_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign fv_q   = st_q.fv;
    assign lv_q   = st_q.lv;
    assign data_q = st_q.data;
    assign thr_q  = st_q.thr;
    assign fwd_q  = st_q.fwd;

    AST_CFG_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q.fv) |-> ($stable(st_q.thr) && $stable(st_q.fwd)
                            && $stable(st_q.fv_inv) && $stable(st_q.lv_inv))); // R8
endmodule

// File: rtl/rfq_setup_cnt.sv
`timescale 1ns/1ps
// Counts qualified FV-active clocks, saturating at the threshold.
module rfq_setup_cnt #(
    parameter int THR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fv,
    input  logic [THR_W-1:0] thr,
    output logic             met
);
    typedef struct packed {
        logic [THR_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!fv) begin
            st_d.cnt = '0;
        end else if (st_q.cnt < thr) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign met = (st_q.cnt >= thr);

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= thr); // R3
    AST_CNT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        !fv |=> (st_q.cnt == '0)); // R3
endmodule

// File: rtl/rfq_line_gate.sv
`timescale 1ns/1ps
// First-line decision, output gating and sticky error.
module rfq_line_gate
    import rfq_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fv,
    input  logic              lv,
    input  logic [DATA_W-1:0] data,
    input  logic              met,
    input  logic              fwd,
    input  logic              err_clr,
    output logic              fv_o,
    output logic              lv_o,
    output logic              vld_o,
    output logic [DATA_W-1:0] data_o,
    output logic              err_o
);
    typedef struct packed {
        line_st_e          st;
        logic              lv_prev;
        logic              fv_o;
        logic              lv_o;
        logic              vld;
        logic [DATA_W-1:0] data;
        logic              err;
    } gate_st_t;

    gate_st_t st_d, st_q;
    line_st_e cur_st;
    logic     lv_rise;
    logic     keep;
    logic     pass;
    logic     set_err;

    always_comb begin
        st_d       = st_q;
        keep       = 1'b0;
        pass       = 1'b0;
        set_err    = 1'b0;
        lv_rise    = lv & ~st_q.lv_prev;
        cur_st     = (st_q.st == LS_IDLE) ? LS_ARMED : st_q.st;
        st_d.lv_prev = lv;

        if (!fv) begin
            st_d.st = LS_IDLE;
        end else begin
            case (cur_st)
                LS_ARMED: begin
                    st_d.st = LS_ARMED;
                    if (lv_rise) begin
                        if (met) begin
                            st_d.st = LS_PASS;
                            keep    = 1'b1;
                            pass    = 1'b1;
                        end else if (fwd) begin
                            st_d.st = LS_TRUNC;
                            keep    = 1'b1;
                            set_err = 1'b1;
                        end else begin
                            st_d.st = LS_DROP;
                            set_err = 1'b1;
                        end
                    end
                end
                LS_DROP: begin
                    st_d.st = lv ? LS_DROP : LS_PASS;
                end
                LS_TRUNC: begin
                    keep    = 1'b1;
                    pass    = met;
                    st_d.st = lv ? LS_TRUNC : LS_PASS;
                end
                default: begin
                    keep    = 1'b1;
                    pass    = 1'b1;
                    st_d.st = LS_PASS;
                end
            endcase
        end

        st_d.fv_o = fv;
        st_d.lv_o = fv & lv & keep;
        st_d.vld  = fv & lv & keep & pass;
        st_d.data = data;

        if (set_err)      st_d.err = 1'b1;
        else if (err_clr) st_d.err = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.st <= LS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign fv_o   = st_q.fv_o;
    assign lv_o   = st_q.lv_o;
    assign vld_o  = st_q.vld;
    assign data_o = st_q.data;
    assign err_o  = st_q.err;

    AST_LV_INSIDE_FV: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lv_o |-> st_q.fv_o); // R9
    AST_PIX_INSIDE_LV: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> st_q.lv_o); // R5
    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |=> st_q.err); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !err_clr) |=> st_q.err); // R7
    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == LS_DROP && lv) |=> !st_q.lv_o); // R4
endmodule

// File: rtl/raw_frame_qualifier.sv
`timescale 1ns/1ps
module raw_frame_qualifier #(
    parameter int DATA_W  = 12,
    parameter int THR_W   = 16,
    parameter int MIN_RST = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fv_in,
    input  logic              lv_in,
    input  logic [DATA_W-1:0] pix_in,
    input  logic              cfg_fv_inv,
    input  logic              cfg_lv_inv,
    input  logic [THR_W-1:0]  cfg_min_time,
    input  logic              cfg_fwd_trunc,
    input  logic              err_clr,
    output logic              fv_out,
    output logic              lv_out,
    output logic              pix_vld,
    output logic [DATA_W-1:0] pix_out,
    output logic              err_flag
);
    logic              fv_c;
    logic              lv_c;
    logic [DATA_W-1:0] data_c;
    logic [THR_W-1:0]  thr_c;
    logic              fwd_c;
    logic              met_c;

    rfq_input_stage #(
        .DATA_W (DATA_W),
        .THR_W  (THR_W),
        .MIN_RST(MIN_RST)
    ) u_input (
        .clk       (clk),
        .rst_n     (rst_n),
        .fv_raw    (fv_in),
        .lv_raw    (lv_in),
        .data_raw  (pix_in),
        .cfg_fv_inv(cfg_fv_inv),
        .cfg_lv_inv(cfg_lv_inv),
        .cfg_min   (cfg_min_time),
        .cfg_fwd   (cfg_fwd_trunc),
        .fv_q      (fv_c),
        .lv_q      (lv_c),
        .data_q    (data_c),
        .thr_q     (thr_c),
        .fwd_q     (fwd_c)
    );

    rfq_setup_cnt #(
        .THR_W(THR_W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .fv   (fv_c),
        .thr  (thr_c),
        .met  (met_c)
    );

    rfq_line_gate #(
        .DATA_W(DATA_W)
    ) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .fv     (fv_c),
        .lv     (lv_c),
        .data   (data_c),
        .met    (met_c),
        .fwd    (fwd_c),
        .err_clr(err_clr),
        .fv_o   (fv_out),
        .lv_o   (lv_out),
        .vld_o  (pix_vld),
        .data_o (pix_out),
        .err_o  (err_flag)
    );

    AST_OUT_FV_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        fv_out == $past(fv_c)); // R12
endmodule

// File: tb/raw_frame_qualifier_bench.sv
`timescale 1ns/1ps
module raw_frame_qualifier_bench;
    localparam int DW = 12;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fv_in, lv_in, cfg_fv_inv, cfg_lv_inv, cfg_fwd_trunc, err_clr;
    logic [DW-1:0] pix_in;
    logic [TW-1:0] cfg_min_time;
    logic          fv_out, lv_out, pix_vld, err_flag;
    logic [DW-1:0] pix_out;

    always #2.5 clk = ~clk;

    raw_frame_qualifier #(.DATA_W(DW), .THR_W(TW), .MIN_RST(128)) u_raw_frame_qualifier (
        .clk(clk), .rst_n(rst_n), .fv_in(fv_in), .lv_in(lv_in), .pix_in(pix_in),
        .cfg_fv_inv(cfg_fv_inv), .cfg_lv_inv(cfg_lv_inv), .cfg_min_time(cfg_min_time),
        .cfg_fwd_trunc(cfg_fwd_trunc), .err_clr(err_clr),
        .fv_out(fv_out), .lv_out(lv_out), .pix_vld(pix_vld), .pix_out(pix_out),
        .err_flag(err_flag)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int c_fv, c_lv, c_pix, c_lines;
    logic lv_prev_mon = 1'b0;

    always @(negedge clk) begin
        c_fv  += int'(fv_out);
        c_lv  += int'(lv_out);
        c_pix += int'(pix_vld);
        if (lv_out && !lv_prev_mon) c_lines++;
        lv_prev_mon = lv_out;
    end

    task automatic step();
        @(negedge clk);
        pix_in = pix_in + 1'b1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_counts();
        c_fv = 0; c_lv = 0; c_pix = 0; c_lines = 0;
    endtask

    task automatic prep(input bit ifv, input bit ilv, input int mn, input bit fwd);
        cfg_fv_inv = ifv; cfg_lv_inv = ilv;
        cfg_min_time = TW'(mn); cfg_fwd_trunc = fwd;
        fv_in = ifv; lv_in = ilv;
        repeat (5) step();
        err_clr = 1'b1; step(); err_clr = 1'b0;
        repeat (3) step();
        clr_counts();
    endtask

    task automatic frame(input bit ifv, input bit ilv, input int npre, input int l1,
                         input int gap, input int l2, input int tail);
        fv_in = ~ifv;
        for (int i = 0; i < npre; i++) step();
        lv_in = ~ilv;
        for (int i = 0; i < l1; i++) step();
        lv_in = ilv;
        for (int i = 0; i < gap; i++) step();
        lv_in = ~ilv;
        for (int i = 0; i < l2; i++) step();
        lv_in = ilv;
        for (int i = 0; i < tail; i++) step();
        fv_in = ifv;
        repeat (6) step();
    endtask

    task automatic t_reset();
        chk("R1 outputs after reset", int'({fv_out, lv_out, pix_vld, err_flag}), 0);
    endtask

    task automatic t_latency();
        prep(0, 0, 0, 0);
        fv_in = 1'b1; pix_in = 12'h0A5;
        @(negedge clk);
        chk("R12 fv_out one clock after", int'(fv_out), 0);
        @(negedge clk);
        chk("R12 fv_out two clocks after", int'(fv_out), 1);
        chk("R12 pix_out two clocks after", int'(pix_out), 'h0A5);
        fv_in = 1'b0;
        repeat (6) step();
    endtask

    task automatic t_met();
        prep(0, 0, 8, 0);
        frame(0, 0, 8, 10, 3, 7, 2);
        chk("R3 lines at exact threshold", c_lines, 2);
        chk("R3 lv cycles at exact threshold", c_lv, 17);
        chk("R6 pixels with setup met", c_pix, 17);
        chk("R3 no error when met", int'(err_flag), 0);
    endtask

    task automatic t_drop();
        prep(0, 0, 8, 0);
        frame(0, 0, 7, 10, 3, 7, 2);
        chk("R4 lines with short setup", c_lines, 1);
        chk("R4 lv cycles with first dropped", c_lv, 7);
        chk("R6 second line pixels after drop", c_pix, 7);
        chk("R4 error set on drop", int'(err_flag), 1);
        repeat (5) step();
        chk("R7 error sticky", int'(err_flag), 1);
        err_clr = 1'b1; step(); err_clr = 1'b0; step();
        chk("R7 error cleared", int'(err_flag), 0);
    endtask

    task automatic t_trunc();
        prep(0, 0, 8, 1);
        frame(0, 0, 5, 10, 3, 7, 2);
        chk("R5 lines truncated mode", c_lines, 2);
        chk("R5 lv cycles truncated mode", c_lv, 17);
        chk("R5 pixels truncated mode", c_pix, 14);
        chk("R5 error on truncation", int'(err_flag), 1);
    endtask

    task automatic t_pol();
        prep(1, 1, 4, 0);
        frame(1, 1, 6, 10, 3, 7, 2);
        chk("R2 fv cycles both inverted", c_fv, 28);
        chk("R2 lv cycles both inverted", c_lv, 17);
        chk("R2 no error both inverted", int'(err_flag), 0);
        prep(1, 0, 4, 0);
        frame(1, 0, 6, 10, 3, 7, 2);
        chk("R2 lv cycles fv-only inverted", c_lv, 17);
        chk("R2 fv cycles fv-only inverted", c_fv, 28);
    endtask

    task automatic t_zero();
        prep(0, 0, 0, 0);
        frame(0, 0, 0, 10, 3, 7, 2);
        chk("R10 same-clock rise threshold 0", c_lv, 17);
        chk("R10 no error threshold 0", int'(err_flag), 0);
        prep(0, 0, 1, 0);
        frame(0, 0, 0, 10, 3, 7, 2);
        chk("R10 same-clock rise threshold 1", c_lv, 7);
        chk("R10 error threshold 1", int'(err_flag), 1);
    endtask

    task automatic t_shadow();
        prep(0, 0, 4, 0);
        fv_in = 1'b1;
        repeat (2) step();
        cfg_min_time = TW'(100); cfg_fwd_trunc = 1'b1;
        repeat (4) step();
        lv_in = 1'b1; repeat (10) step();
        lv_in = 1'b0; repeat (3) step();
        lv_in = 1'b1; repeat (7) step();
        lv_in = 1'b0; repeat (2) step();
        fv_in = 1'b0; repeat (6) step();
        chk("R8 mid-frame change ignored lv", c_lv, 17);
        chk("R8 mid-frame change ignored err", int'(err_flag), 0);
        clr_counts();
        frame(0, 0, 6, 10, 3, 7, 2);
        chk("R8 new setting next frame lv", c_lv, 17);
        chk("R8 new setting next frame pix", c_pix, 7);
        chk("R8 new setting next frame err", int'(err_flag), 1);
    endtask

    task automatic t_outside();
        prep(0, 0, 4, 0);
        lv_in = 1'b1; repeat (5) step();
        lv_in = 1'b0; repeat (4) step();
        chk("R9 lv outside fv", c_lv, 0);
        chk("R9 no error outside fv", int'(err_flag), 0);
        lv_in = 1'b1; repeat (2) step();
        fv_in = 1'b1; repeat (8) step();
        lv_in = 1'b0; repeat (2) step();
        lv_in = 1'b1; repeat (5) step();
        lv_in = 1'b0; step();
        fv_in = 1'b0; repeat (6) step();
        chk("R9 held line excluded lv", c_lv, 5);
        chk("R9 held line excluded lines", c_lines, 1);
    endtask

    task automatic t_eof();
        prep(0, 0, 4, 0);
        fv_in = 1'b1; repeat (6) step();
        lv_in = 1'b1; repeat (5) step();
        fv_in = 1'b0; repeat (4) step();
        lv_in = 1'b0; repeat (4) step();
        chk("R11 lv ends with fv", c_lv, 5);
        chk("R11 no end-of-frame error", int'(err_flag), 0);
    endtask

    task automatic t_collide();
        prep(0, 0, 8, 0);
        fv_in = 1'b1; repeat (3) step();
        lv_in = 1'b1; step();
        err_clr = 1'b1; step(); err_clr = 1'b0;
        repeat (5) step();
        lv_in = 1'b0; fv_in = 1'b0; repeat (6) step();
        chk("R7 set wins over clear", int'(err_flag), 1);
        err_clr = 1'b1; step(); err_clr = 1'b0; step();
        chk("R7 lone clear", int'(err_flag), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        fv_in = 1'b0; lv_in = 1'b0; pix_in = '0;
        cfg_fv_inv = 1'b0; cfg_lv_inv = 1'b0; cfg_min_time = TW'(128);
        cfg_fwd_trunc = 1'b0; err_clr = 1'b0;
        clr_counts();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_latency();
        t_met();
        t_drop();
        t_trunc();
        t_pol();
        t_zero();
        t_shadow();
        t_outside();
        t_eof();
        t_collide();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule